// File: doc/BRIEF.md
# Data EEPROM Access Controller

This block gives a small processor byte-wide access to an on-chip nonvolatile data store of 128 bytes. The store is modelled as a register array inside the block and is not cleared by any reset. Software reaches the block over a simple register bus made of a 2-bit register select, a write strobe, a write byte and a combinational read byte. Four registers sit on that bus: control, unlock, address and data.

A read takes one cycle. A write is guarded against stray stores. Software must first set the write-enable bit, then write 0x55 and 0xAA to the unlock register on consecutive bus writes, and then set the write start bit on the very next bus write. The write then runs for a fixed, parameterised number of clock cycles. The byte is committed to the array only at the end of that count. A completion flag is then raised and stays set until it is cleared.

A warm reset (master-clear or watchdog) that arrives during a write abandons the write. It records the abandoned write in a sticky error flag and clears the address and data registers, so software can see what happened and try the write again.

Top module: `nvdata_ctrl`

## Requirements
- R1: Register select values: 0 = control, 1 = unlock, 2 = address, 3 = data. In the control register, bit 0 is the read start, bit 1 the write start, bit 2 write enable and bit 3 the error flag. Bits 7..4 always read 0 and ignore writes.
- R2: Writing 1 to the read or write start bit sets it. Writing 0 to either bit leaves it unchanged.
- R3: Setting the read start bit makes it read 1 for exactly one cycle. On the next clock it clears, and the data register holds the array byte at the current address.
- R4: A write starts only when all of the following hold: 0x55 and then 0xAA are written to the unlock register on consecutive bus writes; the next bus write goes to the control register with bit 1 set; write enable was already 1 before that bus write. Any other bus write disarms the sequence.
- R5: While a write runs, the write start bit reads 1 for WR_CYCLES cycles. The array is updated only when that count ends.
- R6: When a write completes, the write start bit clears, the error flag clears and `done_flag` is set. `done_flag` stays set until `done_clr` is pulsed.
- R7: While a write is running, bus writes to the control, address, data and unlock registers have no effect.
- R8: If `warm_rst` arrives during a write, the error flag is set, the address and data registers become 0, the write is abandoned and the array byte is unchanged. `warm_rst` always clears write enable, the start bits and the address and data registers. It leaves the error flag unchanged when no write is running.
- R9: After power-on reset (`rst_n` low), every register reads 0 and `done_flag` is 0.
- R10: The unlock register has no storage and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous active low, released synchronously inside |
| warm_rst | input | 1 | Warm reset pulse (master-clear or watchdog), synchronous, active high |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Bus write strobe |
| reg_wdata | input | 8 | Bus write byte |
| reg_rdata | output | 8 | Read byte of the selected register |
| done_flag | output | 1 | Write-complete interrupt flag |
| done_clr | input | 1 | Clears `done_flag` |

## Verification
The hardest state to reach from the ports is a warm reset that lands inside a timed write. To get there, the stimulus first stores a known byte at an address. It then performs the full enable, unlock and start sequence with a different byte and pulses `warm_rst` a few cycles into the count. A read-back of the same address then shows that the array byte is unchanged. Writes sent while a store is running, and unlock sequences that are broken or sent in the wrong order, are driven the same way, and each is followed by a read-back of the registers and the array.

// File: rtl/nvdata_pkg.sv
package nvdata_pkg;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_UNLOCK = 2'd1,
    REG_ADDR   = 2'd2,
    REG_DATA   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ULK_IDLE  = 2'd0,
    ULK_HALF  = 2'd1,
    ULK_ARMED = 2'd2
  } ulk_state_e;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int unsigned BIT_RD   = 0;
  localparam int unsigned BIT_WR   = 1;
  localparam int unsigned BIT_WREN = 2;
  localparam int unsigned BIT_ERR  = 3;

endpackage

// File: rtl/nvdata_unlock.sv
module nvdata_unlock
  import nvdata_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bus_we,
  input  logic          sel_unlock,
  input  logic [DW-1:0] wdata,
  output logic          armed
);

  ulk_state_e state_q;
  ulk_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (clr) begin
      state_d = ULK_IDLE;
    end else if (bus_we) begin
      if (sel_unlock && (wdata[7:0] == KEY_FIRST)) begin
        state_d = ULK_HALF;
      end else if (sel_unlock && (state_q == ULK_HALF) && (wdata[7:0] == KEY_SECOND)) begin
        state_d = ULK_ARMED;
      end else begin
        state_d = ULK_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ULK_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign armed = (state_q == ULK_ARMED);

endmodule

// File: rtl/nvdata_timer.sv
module nvdata_timer #(
  parameter int unsigned WR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic busy,
  output logic finish
);

  localparam int unsigned CW = (WR_CYCLES > 2) ? $clog2(WR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WR_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          cnt_en;

  assign finish = busy_q && (cnt_q == LAST);
  assign cnt_en = clr || start || busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (clr) begin
      cnt_d  = '0;
      busy_d = 1'b0;
    end else if (start) begin
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (finish) begin
      cnt_d  = '0;
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/nvdata_array.sv
module nvdata_array #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/nvdata_ctrl.sv
module nvdata_ctrl
  import nvdata_pkg::*;
#(
  parameter int unsigned DEPTH     = 128,
  parameter int unsigned DW        = 8,
  parameter int unsigned WR_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warm_rst,
  input  logic [1:0]    reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          done_flag,
  input  logic          done_clr
);

  localparam int unsigned AW = $clog2(DEPTH);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_addr);

  logic          rd_q, rd_d;
  logic          wr_q, wr_d;
  logic          wren_q, wren_d;
  logic          err_q, err_d;
  logic          done_q, done_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;

  logic          sw_we;
  logic          armed;
  logic          start_wr;
  logic          t_busy;
  logic          t_finish;
  logic          commit;
  logic [DW-1:0] arr_rdata;

  // writes are gated off for the whole timed write
  assign sw_we    = reg_we && !wr_q && !warm_rst;
  assign start_wr = sw_we && (sel == REG_CTRL) && armed && wren_q && reg_wdata[BIT_WR];
  assign commit   = t_finish && !warm_rst;

  nvdata_unlock #(.DW(DW)) u_unlock (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr        (warm_rst || wr_q),
    .bus_we     (sw_we),
    .sel_unlock (sel == REG_UNLOCK),
    .wdata      (reg_wdata),
    .armed      (armed)
  );

  nvdata_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (warm_rst),
    .start  (start_wr),
    .busy   (t_busy),
    .finish (t_finish)
  );

  nvdata_array #(.DEPTH(DEPTH), .DW(DW)) u_array (
    .clk   (clk),
    .we    (commit),
    .addr  (addr_q),
    .wdata (data_q),
    .rdata (arr_rdata)
  );

  always_comb begin
    rd_d   = rd_q;
    wr_d   = wr_q;
    wren_d = wren_q;
    err_d  = err_q;
    addr_d = addr_q;
    data_d = data_q;
    if (warm_rst) begin
      err_d  = err_q || wr_q;
      rd_d   = 1'b0;
      wr_d   = 1'b0;
      wren_d = 1'b0;
      addr_d = '0;
      data_d = '0;
    end else begin
      if (commit) begin
        wr_d  = 1'b0;
        err_d = 1'b0;
      end
      if (rd_q) begin
        rd_d   = 1'b0;
        data_d = arr_rdata;
      end
      if (sw_we) begin
        unique case (sel)
          REG_CTRL: begin
            if (reg_wdata[BIT_RD]) rd_d = 1'b1;
            if (start_wr)          wr_d = 1'b1;
            wren_d = reg_wdata[BIT_WREN];
            err_d  = reg_wdata[BIT_ERR];
          end
          REG_ADDR:   addr_d = reg_wdata[AW-1:0];
          REG_DATA:   data_d = reg_wdata;
          REG_UNLOCK: ;
          default:    ;
        endcase
      end
    end
  end

  always_comb begin
    done_d = done_q;
    if (done_clr) done_d = 1'b0;
    if (commit)   done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      wren_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      wren_q <= wren_d;
      err_q  <= err_d;
      done_q <= done_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      REG_CTRL: begin
        reg_rdata[BIT_RD]   = rd_q;
        reg_rdata[BIT_WR]   = wr_q;
        reg_rdata[BIT_WREN] = wren_q;
        reg_rdata[BIT_ERR]  = err_q;
      end
      REG_ADDR:   reg_rdata = {{(DW-AW){1'b0}}, addr_q};
      REG_DATA:   reg_rdata = data_q;
      REG_UNLOCK: reg_rdata = '0;
      default:    reg_rdata = '0;
    endcase
  end

  assign done_flag = done_q;

  logic unused_busy;
  assign unused_busy = t_busy;

endmodule

// File: rtl/nvdata_ctrl_chk.sv
module nvdata_ctrl_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          warm_rst,
  input logic [1:0]    reg_addr,
  input logic          reg_we,
  input logic [DW-1:0] reg_rdata,
  input logic          done_flag,
  input logic          done_clr,
  input logic          rd_q,
  input logic          wr_q,
  input logic          err_q,
  input logic [AW-1:0] addr_q,
  input logic [DW-1:0] data_q
);

  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[DW-1:4] == '0)); // R1

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |=> !rd_q); // R3

  AST_WR_END_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_q) |-> ($past(warm_rst) || done_flag)); // R6

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !done_clr) |=> done_flag); // R6

  AST_BUSY_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && reg_we && (reg_addr == 2'd2) && !warm_rst) |=> $stable(addr_q)); // R7

  AST_WARM_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && warm_rst) |=> (err_q && (addr_q == '0) && (data_q == '0) && !wr_q)); // R8

  AST_UNLOCK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> (reg_rdata == '0)); // R10

endmodule

bind nvdata_ctrl nvdata_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .warm_rst  (warm_rst),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .reg_rdata (reg_rdata),
  .done_flag (done_flag),
  .done_clr  (done_clr),
  .rd_q      (rd_q),
  .wr_q      (wr_q),
  .err_q     (err_q),
  .addr_q    (addr_q),
  .data_q    (data_q)
);

// File: tb/tb_nvdata_ctrl.sv
`timescale 1ns/1ps
module tb_nvdata_ctrl;

  localparam int W = 16;
  localparam logic [1:0] A_CTRL = 2'd0, A_ULK = 2'd1, A_ADDR = 2'd2, A_DATA = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       warm_rst;
  logic [1:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       done_flag;
  logic       done_clr;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nvdata_ctrl #(.WR_CYCLES(W)) dut (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .done_flag(done_flag), .done_clr(done_clr)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic arr_read(input logic [7:0] a, output logic [7:0] v);
    logic [7:0] c;
    bus_wr(A_ADDR, a);
    bus_wr(A_CTRL, 8'h01);
    peek(A_CTRL, c);
    check("R3", "read start visible", c & 8'h01, 8'h01);
    @(negedge clk);
    peek(A_CTRL, c);
    check("R3", "read start self-clears", c & 8'h01, 8'h00);
    peek(A_DATA, v);
  endtask

  task automatic arm_and_start(input logic [7:0] a, input logic [7:0] d, input logic [7:0] go);
    bus_wr(A_CTRL, 8'h04);
    bus_wr(A_ADDR, a);
    bus_wr(A_DATA, d);
    bus_wr(A_ULK, 8'h55);
    bus_wr(A_ULK, 8'hAA);
    bus_wr(A_CTRL, go);
  endtask

  task automatic pulse_done_clr;
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    peek(A_CTRL, v); check("R9", "ctrl after reset", v, 8'h00);
    peek(A_ADDR, v); check("R9", "addr after reset", v, 8'h00);
    peek(A_DATA, v); check("R9", "data after reset", v, 8'h00);
    peek(A_ULK, v);  check("R10", "unlock reads zero", v, 8'h00);
    check("R9", "done after reset", {7'd0, done_flag}, 8'h00);
  endtask

  task automatic t_ctrl_bits;
    logic [7:0] v;
    bus_wr(A_CTRL, 8'hF0);
    peek(A_CTRL, v); check("R1", "upper bits ignored", v, 8'h00);
    bus_wr(A_CTRL, 8'h04);
    peek(A_CTRL, v); check("R1", "write enable bit 2", v, 8'h04);
    bus_wr(A_CTRL, 8'h06);
    peek(A_CTRL, v); check("R4", "start without unlock ignored", v, 8'h04);
    bus_wr(A_ULK, 8'h5A);
    peek(A_ULK, v); check("R10", "unlock still zero", v, 8'h00);
  endtask

  task automatic t_good_write;
    logic [7:0] v;
    arm_and_start(8'h05, 8'hA5, 8'h06);
    peek(A_CTRL, v); check("R5", "write start held", v, 8'h06);
    repeat (W - 1) @(negedge clk);
    peek(A_CTRL, v); check("R5", "still busy at count-1", v, 8'h06);
    check("R5", "no done before count end", {7'd0, done_flag}, 8'h00);
    @(negedge clk);
    peek(A_CTRL, v); check("R6", "write start cleared", v, 8'h04);
    check("R6", "done set", {7'd0, done_flag}, 8'h01);
    repeat (3) @(negedge clk);
    check("R6", "done sticky", {7'd0, done_flag}, 8'h01);
    pulse_done_clr();
    check("R6", "done cleared by done_clr", {7'd0, done_flag}, 8'h00);
    bus_wr(A_DATA, 8'h00);
    arr_read(8'h05, v);
    check("R3", "read back stored byte", v, 8'hA5);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] v;
    arm_and_start(8'h06, 8'h3E, 8'h06);
    bus_wr(A_CTRL, 8'h00);
    bus_wr(A_ADDR, 8'h10);
    bus_wr(A_DATA, 8'h77);
    peek(A_CTRL, v); check("R2", "zero cannot clear write start", v, 8'h06);
    peek(A_ADDR, v); check("R7", "addr held during write", v, 8'h06);
    peek(A_DATA, v); check("R7", "data held during write", v, 8'h3E);
    for (int i = 0; i < 4 * W && reg_rdata != 8'h3E; i++) @(negedge clk);
    for (int i = 0; i < 4 * W; i++) begin
      peek(A_CTRL, v);
      if (v[1] == 1'b0) break;
      @(negedge clk);
    end
    pulse_done_clr();
    arr_read(8'h06, v); check("R7", "array kept original byte", v, 8'h3E);
    arr_read(8'h10, v); check("R7", "ignored addr not written", v === 8'h3E ? 8'h00 : 8'h01, 8'h01);
  endtask

  task automatic t_bad_unlock;
    logic [7:0] v;
    bus_wr(A_CTRL, 8'h04);
    bus_wr(A_ULK, 8'hAA);
    bus_wr(A_ULK, 8'h55);
    bus_wr(A_CTRL, 8'h06);
    peek(A_CTRL, v); check("R4", "reverse key order no start", v, 8'h04);
    bus_wr(A_ULK, 8'h55);
    bus_wr(A_DATA, 8'h11);
    bus_wr(A_ULK, 8'hAA);
    bus_wr(A_CTRL, 8'h06);
    peek(A_CTRL, v); check("R4", "interrupted keys no start", v, 8'h04);
    bus_wr(A_CTRL, 8'h00);
    bus_wr(A_ULK, 8'h55);
    bus_wr(A_ULK, 8'hAA);
    bus_wr(A_CTRL, 8'h06);
    peek(A_CTRL, v); check("R4", "enable not pre-set no start", v, 8'h04);
    repeat (W + 2) @(negedge clk);
    check("R4", "no done after refused starts", {7'd0, done_flag}, 8'h00);
  endtask

  task automatic t_warm_abort;
    logic [7:0] v;
    arm_and_start(8'h09, 8'h3C, 8'h06);
    repeat (W + 1) @(negedge clk);
    pulse_done_clr();
    arm_and_start(8'h09, 8'hC3, 8'h06);
    repeat (3) @(negedge clk);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    peek(A_CTRL, v); check("R8", "error set, start cleared", v, 8'h08);
    peek(A_ADDR, v); check("R8", "addr cleared", v, 8'h00);
    peek(A_DATA, v); check("R8", "data cleared", v, 8'h00);
    repeat (W + 2) @(negedge clk);
    check("R8", "no done after abort", {7'd0, done_flag}, 8'h00);
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0;
    peek(A_CTRL, v); check("R8", "error kept over idle warm reset", v, 8'h08);
    arr_read(8'h09, v); check("R8", "array byte unchanged", v, 8'h3C);
    bus_wr(A_CTRL, 8'h0C);
    peek(A_CTRL, v); check("R1", "error bit 3 writable", v, 8'h0C);
    bus_wr(A_ULK, 8'h55);
    bus_wr(A_ULK, 8'hAA);
    bus_wr(A_CTRL, 8'h0E);
    repeat (W) @(negedge clk);
    peek(A_CTRL, v); check("R6", "completion clears error", v, 8'h04);
    pulse_done_clr();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; warm_rst = 1'b0; reg_addr = 2'd0; reg_we = 1'b0;
    reg_wdata = 8'h00; done_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ctrl_bits();
    t_good_write();
    t_busy_ignore();
    t_bad_unlock();
    t_warm_abort();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule